// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

This block sits in a two-pipe in-order issue stage. Each cycle it receives two pre-decoded instruction descriptors: the older instruction, aimed at the U pipe, and the younger one, aimed at the V pipe. It decides whether the two may issue together in the same cycle. When they may not, it reports the first rule that blocked them.

The rules are these:
- Both instructions must be simple.
- Some classes are tied to one pipe. Shifts and carry arithmetic may only be in U. Branches may only be in V. Prefixed opcodes may only be in U.
- No instruction may carry both a displacement and an immediate.
- A multi-byte U instruction pairs only once it has already run from the cache.
- Register dependencies between the two slots block pairing, with two exceptions:
  - a flag producer followed by a conditional jump;
  - back-to-back pushes or back-to-back pops.

The result is registered. It appears one cycle after the input strobe, with its own valid bit. A two-state controller (`S_IDLE`, `S_REPORT`) tracks whether a result is being presented. The transitions are:
- `S_IDLE` goes to `S_REPORT` on `in_valid`.
- `S_REPORT` stays in `S_REPORT` on `in_valid`.
- `S_REPORT` returns to `S_IDLE` when `in_valid` is low.
- Reset forces `S_IDLE`.

Top module: `pair_issue_checker`

## Requirements
- R1: A result is presented (`res_valid`=1) exactly in the cycle after a cycle with `in_valid`=1, and never otherwise. Reset clears `res_valid`, `res_pair` and `res_reason` to 0.
- R2: `res_pair` is 1 exactly when `res_reason` is 0. When several rules fail, the reported code is the smallest failing one: 1 not simple, 2 pipe-class, 3 displacement with immediate, 4 prefix, 5 length, 6 dependency.
- R3: Code 1 is reported when either slot:
  - has simple (descriptor bit 0) clear; or
  - has segment-use (bit 9) set; or
  - is a rotate-through-carry (bit 12) with an immediate (bit 11) whose count is not one (count-is-one, bit 13, clear).
- R4: Code 2 is reported when the V slot has shift (bit 1) or carry-arithmetic (bit 2) set, or when the U slot has branch (bit 3) set. The same classes in their allowed slot do not block.
- R5: Code 3 is reported when either slot has both displacement (bit 10) and immediate (bit 11). Either flag alone does not block.
- R6: Code 4 is reported when the V slot has prefixed (bit 7) set and 0Fh-conditional-jump (bit 8) clear. A prefixed U slot does not block.
- R7: Code 5 is reported when the U slot length field (bits 19:16) exceeds 1 and its cache-history bit (bit 15) is clear. The V slot length has no effect.
- R8: Code 6 is reported when the V read mask (bits 27:20) overlaps the U write mask (bits 35:28), or when the two write masks overlap. Bit n of a mask is general register n.
- R9: Code 6 is reported when U writes flags (bit 37) and V reads flags (bit 36). The exception is a U that is a flag-setting ALU or INC/DEC op (bit 14) followed by a V that is a conditional jump (bit 4).
- R10: Register 4, the stack pointer, is left out of the R8 check only when both slots are pushes (bit 5) or both are pops (bit 6). Any other stack-pointer dependency gives code 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor pair is present this cycle |
| u_desc | input | 38 | Older instruction descriptor (U slot) |
| v_desc | input | 38 | Younger instruction descriptor (V slot) |
| res_valid | output | 1 | Result of previous cycle's pair is present |
| res_pair | output | 1 | 1 = may dual-issue |
| res_reason | output | 4 | Blocking rule code, 0 when paired |

## Verification
The hardest case to reach is the ordering between rules. Most descriptor pairs break only one rule, so the priority chain is never exercised on its own. The stimulus therefore includes crafted pairs that break two adjacent rules at once, such as a V-slot shift that also carries a displacement and an immediate, or a long uncached U op that also has a register hazard. Each such pair must report the lower code.

The stack-pointer exception is the other subtle case. It is driven with push/push, push/pop and push-then-stack-read pairs that differ only in their class bits.

// File: rtl/pair_pkg.sv
package pair_pkg;
    localparam int NUM_REGS = 8;
    localparam int LEN_W    = 4;
    localparam int REASON_W = 4;

    typedef struct packed {
        logic                flags_wr;
        logic                flags_rd;
        logic [NUM_REGS-1:0] reg_wr;
        logic [NUM_REGS-1:0] reg_rd;
        logic [LEN_W-1:0]    length;
        logic                cached;
        logic                alu_flags;
        logic                count_one;
        logic                rc_rotate;
        logic                has_imm;
        logic                has_disp;
        logic                seg_use;
        logic                jcc_0f;
        logic                prefixed;
        logic                pop;
        logic                push;
        logic                cond_jump;
        logic                branch;
        logic                carry_arith;
        logic                shift;
        logic                simple;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    typedef enum logic [REASON_W-1:0] {
        RSN_PAIRED     = 4'd0,
        RSN_NOT_SIMPLE = 4'd1,
        RSN_PIPE_CLASS = 4'd2,
        RSN_DISP_IMM   = 4'd3,
        RSN_PREFIX     = 4'd4,
        RSN_LENGTH     = 4'd5,
        RSN_HAZARD     = 4'd6
    } reason_e;

    typedef struct packed {
        logic not_simple;
        logic pipe_class;
        logic disp_imm;
        logic prefix;
        logic length;
    } slot_viol_t;
endpackage

// File: rtl/pair_slot_rules.sv
module pair_slot_rules
    import pair_pkg::*;
#(
    parameter bit IS_U_SLOT = 1'b1
) (
    input  desc_t      d,
    output slot_viol_t viol
);
    logic rc_bad_count;

    always_comb begin
        rc_bad_count    = d.rc_rotate && d.has_imm && !d.count_one;
        viol.not_simple = !d.simple || d.seg_use || rc_bad_count;
        viol.disp_imm   = d.has_disp && d.has_imm;
    end

    generate
        if (IS_U_SLOT) begin : g_u_rules
            always_comb begin
                viol.pipe_class = d.branch;
                viol.prefix     = 1'b0;
                viol.length     = (d.length > LEN_W'(1)) && !d.cached;
            end
        end else begin : g_v_rules
            always_comb begin
                viol.pipe_class = d.shift || d.carry_arith;
                viol.prefix     = d.prefixed && !d.jcc_0f;
                viol.length     = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/pair_hazard_check.sv
module pair_hazard_check
    import pair_pkg::*;
#(
    parameter int SP_IDX = 4
) (
    input  desc_t u,
    input  desc_t v,
    output logic  hazard
);
    logic [NUM_REGS-1:0] sp_keep;
    logic                stack_pair;
    logic                raw_reg;
    logic                waw_reg;
    logic                flag_dep;
    logic                flag_exempt;

    always_comb begin
        stack_pair  = (u.push && v.push) || (u.pop && v.pop);
        sp_keep     = '1;
        if (stack_pair) begin
            sp_keep[SP_IDX] = 1'b0;
        end
        raw_reg     = |(u.reg_wr & v.reg_rd & sp_keep);
        waw_reg     = |(u.reg_wr & v.reg_wr & sp_keep);
        flag_exempt = u.alu_flags && v.cond_jump;
        flag_dep    = u.flags_wr && v.flags_rd && !flag_exempt;
        hazard      = raw_reg || waw_reg || flag_dep;
    end
endmodule

// File: rtl/pair_issue_checker.sv
module pair_issue_checker
    import pair_pkg::*;
#(
    parameter int SP_IDX = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [DESC_W-1:0]   u_desc,
    input  logic [DESC_W-1:0]   v_desc,
    output logic                res_valid,
    output logic                res_pair,
    output logic [REASON_W-1:0] res_reason
);
    typedef enum logic [0:0] { S_IDLE, S_REPORT } state_e;

    state_e     state_q, state_d;
    desc_t      u, v;
    slot_viol_t viol [2];
    logic       hazard;
    reason_e    reason_d;

    assign u = desc_t'(u_desc);
    assign v = desc_t'(v_desc);

    for (genvar s = 0; s < 2; s++) begin : g_slot
        pair_slot_rules #(.IS_U_SLOT(s == 0)) u_rules (
            .d    (s == 0 ? u : v),
            .viol (viol[s])
        );
    end

    pair_hazard_check #(.SP_IDX(SP_IDX)) u_haz (
        .u      (u),
        .v      (v),
        .hazard (hazard)
    );

    always_comb begin
        if (viol[0].not_simple || viol[1].not_simple)      reason_d = RSN_NOT_SIMPLE;
        else if (viol[0].pipe_class || viol[1].pipe_class) reason_d = RSN_PIPE_CLASS;
        else if (viol[0].disp_imm || viol[1].disp_imm)     reason_d = RSN_DISP_IMM;
        else if (viol[0].prefix || viol[1].prefix)         reason_d = RSN_PREFIX;
        else if (viol[0].length || viol[1].length)         reason_d = RSN_LENGTH;
        else if (hazard)                                   reason_d = RSN_HAZARD;
        else                                               reason_d = RSN_PAIRED;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (in_valid)  state_d = S_REPORT;
            S_REPORT: if (!in_valid) state_d = S_IDLE;
            default:                 state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_pair   <= 1'b0;
            res_reason <= '0;
        end else if (in_valid) begin
            res_pair   <= (reason_d == RSN_PAIRED);
            res_reason <= reason_d;
        end
    end

    assign res_valid = (state_q == S_REPORT);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);
    assert_pair_matches_code_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_pair == (res_reason == 4'd0)));
    assert_code_range_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_reason <= 4'd6));
    assert_u_not_simple_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !u.simple) |=> (res_reason == 4'd1));
    assert_v_shift_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && v.shift) |=> !res_pair);
    assert_long_u_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (u.length > LEN_W'(1)) && !u.cached) |=> !res_pair);
    assert_raw_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && |(u.reg_wr & v.reg_rd & ~(NUM_REGS'(1) << SP_IDX))) |=> !res_pair);
endmodule

// File: tb/pair_issue_checker_test.sv
module pair_issue_checker_test;
    localparam int W = 38;

    localparam logic [W-1:0] SIMPLE = W'(1) << 0;
    localparam logic [W-1:0] SHIFT  = W'(1) << 1;
    localparam logic [W-1:0] CARRY  = W'(1) << 2;
    localparam logic [W-1:0] BRANCH = W'(1) << 3;
    localparam logic [W-1:0] CONDJ  = W'(1) << 4;
    localparam logic [W-1:0] PUSH   = W'(1) << 5;
    localparam logic [W-1:0] POP    = W'(1) << 6;
    localparam logic [W-1:0] PREFIX = W'(1) << 7;
    localparam logic [W-1:0] JCC0F  = W'(1) << 8;
    localparam logic [W-1:0] SEG    = W'(1) << 9;
    localparam logic [W-1:0] DISP   = W'(1) << 10;
    localparam logic [W-1:0] IMM    = W'(1) << 11;
    localparam logic [W-1:0] RCROT  = W'(1) << 12;
    localparam logic [W-1:0] CNT1   = W'(1) << 13;
    localparam logic [W-1:0] ALUF   = W'(1) << 14;
    localparam logic [W-1:0] CACHED = W'(1) << 15;
    localparam logic [W-1:0] FRD    = W'(1) << 36;
    localparam logic [W-1:0] FWR    = W'(1) << 37;

    function automatic logic [W-1:0] len(input int n);
        return W'(n) << 16;
    endfunction
    function automatic logic [W-1:0] rd(input int r);
        return W'(1) << (20 + r);
    endfunction
    function automatic logic [W-1:0] wr(input int r);
        return W'(1) << (28 + r);
    endfunction

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] u_desc = '0;
    logic [W-1:0] v_desc = '0;
    logic         res_valid;
    logic         res_pair;
    logic [3:0]   res_reason;

    int    n_vec = 0;
    int    n_bad = 0;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    pair_issue_checker uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .u_desc(u_desc), .v_desc(v_desc),
        .res_valid(res_valid), .res_pair(res_pair), .res_reason(res_reason)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [W-1:0] u, input logic [W-1:0] v,
                        input int exp, input string tag);
        @(negedge clk);
        u_desc   = u;
        v_desc   = v;
        in_valid = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected result", 1, 0);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(res_reason == 4'(e), t, res_reason, e);
                check(res_pair == (e == 0), {t, " pair bit R2"}, res_pair, (e == 0));
            end
        end
    end

    localparam logic [W-1:0] S = SIMPLE | len(1);

    initial begin
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
        check(res_reason == 4'd0 && res_pair == 1'b0, "R1 reset outputs", res_reason, 0);
        rst = 1'b0;

        send(S | wr(0), S | rd(1) | wr(1), 0, "R8 independent pair");
        send(S | wr(0), S | rd(0) | wr(1), 6, "R8 read after write");
        send(S | wr(2), S | wr(2), 6, "R8 write after write");
        send(len(1), S, 1, "R3 U not simple");
        send(S, S | SEG, 1, "R3 V segment use");
        send(S | SHIFT | RCROT | IMM, S, 1, "R3 rotate-carry count>1");
        send(S | SHIFT | RCROT | IMM | CNT1, S, 0, "R3 rotate-carry count 1");
        send(S, S | SHIFT, 2, "R4 shift in V");
        send(S | SHIFT, S, 0, "R4 shift in U");
        send(S, S | CARRY, 2, "R4 carry op in V");
        send(S | BRANCH, S, 2, "R4 branch in U");
        send(S, S | BRANCH, 0, "R4 branch in V");
        send(S | DISP | IMM, S, 3, "R5 U disp+imm");
        send(S, S | DISP | IMM, 3, "R5 V disp+imm");
        send(S | DISP, S | IMM, 0, "R5 single flags");
        send(S, S | PREFIX, 4, "R6 V prefixed");
        send(S, S | PREFIX | JCC0F | BRANCH | CONDJ, 0, "R6 V 0Fh cond jump");
        send(S | PREFIX, S, 0, "R6 U prefixed");
        send(SIMPLE | len(3), S, 5, "R7 U long uncached");
        send(SIMPLE | len(3) | CACHED, S, 0, "R7 U long cached");
        send(S, SIMPLE | len(5), 0, "R7 V long");
        send(S | FWR, S | FRD | BRANCH | CONDJ, 6, "R9 non-ALU flag writer");
        send(S | FWR | ALUF, S | FRD | BRANCH | CONDJ, 0, "R9 ALU then cond jump");
        send(S | FWR | ALUF, S | FRD, 6, "R9 ALU then flag reader");
        send(S | PUSH | rd(4) | wr(4), S | PUSH | rd(4) | wr(4), 0, "R10 push push");
        send(S | POP | rd(4) | wr(4) | wr(1), S | POP | rd(4) | wr(4) | wr(2), 0, "R10 pop pop");
        send(S | PUSH | rd(4) | wr(4), S | POP | rd(4) | wr(4), 6, "R10 push pop");
        send(S | PUSH | rd(4) | wr(4), S | rd(4) | wr(0), 6, "R10 push then sp read");
        send(S | PUSH | rd(4) | wr(4) | wr(3), S | PUSH | rd(4) | wr(4) | rd(3), 6, "R10 push push other reg");
        send(len(1), S | SHIFT, 1, "R2 not simple over pipe");
        send(S, S | SHIFT | DISP | IMM, 2, "R2 pipe over disp+imm");
        send(S | DISP | IMM, S | PREFIX, 3, "R2 disp+imm over prefix");
        send(SIMPLE | len(2), S | PREFIX, 4, "R2 prefix over length");
        send(SIMPLE | len(2) | wr(0), S | rd(0), 5, "R2 length over hazard");
        idle(3);
        check(res_valid == 1'b0, "R1 no result when idle", res_valid, 0);
        send(S, S, 0, "R1 single after gap");
        idle(2);
        check(res_valid == 1'b0, "R1 valid drops", res_valid, 0);
        check(exp_q.size() == 0, "R1 all results seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule